// File: doc/BRIEF.md
# Latency Scoreboard with Pair-Dependent Bypass

This block sits at the issue point of an in-order pipeline. For every architectural register it remembers whether an instruction still in flight writes it, which instruction class wrote it and how many cycles have passed since that write issued. A request arrives with its class, destination register, two source registers and a small vector of guard bits. The block computes how many more cycles the request must wait before it may issue, and it raises an issue grant when that wait is zero.

The wait for a source depends on the producing and the consuming class together. A small ordered table of bypass rules can replace the producer's default latency for particular pairs. Some rules are enabled only by a guard bit of the consumer, while one rule applies with no guard at all. A rewrite of a register still in flight costs the gap between the two classes' default latencies. A read followed by a write costs nothing. Register 0 is never tracked.

Top module: `latency_scoreboard`

## Requirements
- R1: Classes are encoded on `req_class` as 0 = integer, 1 = multiply, 2 = divide, 3 = floating point. Their default true-dependence latencies are 2, 4, 9 and 3. A consumer presented k cycles after its producer issued has a source wait of max(0, L − k).
- R2: A floating-point producer feeding an integer, multiply or divide consumer uses latency 4 when no guarded rule applies.
- R3: Guarded rules, with the guard on `req_guard` bit 0 or bit 1: bit 0 gives floating point to integer latency 2; bit 1 gives floating point to integer latency 5; bit 1 gives multiply to multiply latency 3.
- R4: Among guarded rules that match a pair, the earliest in the order of R3 wins. When no guarded rule matches, the unguarded rule is used, and failing that the default latency. Guard bits alone change nothing.
- R5: A register that was read by an issued instruction can be written by the next instruction with no stall.
- R6: Rewriting a register in flight waits max(0, Lprod − Lcons − k), using default latencies only.
- R7: `stall_cycles` is the largest wait over both sources and the destination. It is computed whether or not `req_valid` is high. `issue_ok` is high exactly when `req_valid` is high and `stall_cycles` is 0.
- R8: Register 0 never causes a wait, and an issue that writes register 0 records nothing.
- R9: An issue replaces any older entry of its destination, so later waits follow the younger writer.
- R10: A synchronous active-high `rst` clears every entry, so all waits read 0 afterwards.
- R11: While an unchanged request is held, `stall_cycles` falls by exactly one each cycle until it reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issue request present |
| req_class | input | 2 | Class of the requesting instruction |
| req_dst | input | 5 | Destination register |
| req_src_a | input | 5 | First source register |
| req_src_b | input | 5 | Second source register |
| req_guard | input | 2 | Guard bits enabling guarded bypass rules |
| issue_ok | output | 1 | Request issues this cycle |
| stall_cycles | output | 4 | Cycles still to wait |

## Verification
A single request can be held back by a source's true dependence and by its destination's output dependence in the same cycle. The bench provokes this by issuing a divide and then a floating-point instruction back to back. It then presents requests that read one of these registers and write the other, in both pairings, so that each kind of wait is the larger one once. The check is that `stall_cycles` equals the larger of the two waits computed by hand, not their sum and not either one alone.

// File: rtl/lsb_pkg.sv
`timescale 1ns/1ps
package lsb_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_FP  = 2'd3
    } op_class_e;

    localparam int LAT_W      = 4;
    localparam int MAX_LAT    = 9;
    localparam int NUM_GUARDS = 2;
    localparam int GSEL_W     = (NUM_GUARDS > 1) ? $clog2(NUM_GUARDS) : 1;
    localparam int NUM_RULES  = 4;
    localparam int NUM_CLS    = 4;

    typedef logic [LAT_W-1:0] lat_t;

    // Per-register tracking state: age counts cycles since the write issued.
    typedef struct packed {
        logic      valid;
        op_class_e cls;
        lat_t      age;
    } sb_entry_t;

    typedef struct packed {
        op_class_e          prod;
        logic [NUM_CLS-1:0] cons_mask;
        logic               guarded;
        logic [GSEL_W-1:0]  guard_sel;
        lat_t               lat;
    } bypass_rule_t;

    function automatic lat_t base_latency(op_class_e c);
        case (c)
            CLS_INT: return lat_t'(2);
            CLS_MUL: return lat_t'(4);
            CLS_DIV: return lat_t'(9);
            default: return lat_t'(3);
        endcase
    endfunction

    // Ordered rule list; earlier guarded entries take priority.
    function automatic bypass_rule_t rule_at(int idx);
        bypass_rule_t r;
        r = '{prod: CLS_INT, cons_mask: '0, guarded: 1'b0, guard_sel: '0, lat: '0};
        case (idx)
            0: r = '{prod: CLS_FP,  cons_mask: 4'b0001, guarded: 1'b1,
                     guard_sel: GSEL_W'(0), lat: lat_t'(2)};
            1: r = '{prod: CLS_FP,  cons_mask: 4'b0001, guarded: 1'b1,
                     guard_sel: GSEL_W'(1), lat: lat_t'(5)};
            2: r = '{prod: CLS_MUL, cons_mask: 4'b0010, guarded: 1'b1,
                     guard_sel: GSEL_W'(1), lat: lat_t'(3)};
            3: r = '{prod: CLS_FP,  cons_mask: 4'b0111, guarded: 1'b0,
                     guard_sel: GSEL_W'(0), lat: lat_t'(4)};
            default: ;
        endcase
        return r;
    endfunction

    function automatic lat_t sat_sub(lat_t a, lat_t b);
        return (a > b) ? lat_t'(a - b) : lat_t'(0);
    endfunction

    // Cost of rewriting a register: gap between default latencies, floored at 0.
    function automatic lat_t out_dep_cost(op_class_e prod, op_class_e cons);
        return sat_sub(base_latency(prod), base_latency(cons));
    endfunction

endpackage

// File: rtl/lsb_entry_file.sv
`timescale 1ns/1ps
module lsb_entry_file
    import lsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  op_class_e       wr_cls,
    output sb_entry_t       ent_q [NUM_REGS]
);

    // Register 0 is never tracked.
    assign ent_q[0] = '{valid: 1'b0, cls: CLS_INT, age: '0};

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[r] <= '{valid: 1'b0, cls: CLS_INT, age: '0};
            end else if (wr_en && (wr_idx == REG_W'(r))) begin
                ent_q[r] <= '{valid: 1'b1, cls: wr_cls, age: lat_t'(1)};
            end else if (ent_q[r].valid && (ent_q[r].age < lat_t'(MAX_LAT))) begin
                ent_q[r].age <= ent_q[r].age + lat_t'(1);
            end
        end

        AST_AGE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            ent_q[r].valid |-> (ent_q[r].age >= lat_t'(1) && ent_q[r].age <= lat_t'(MAX_LAT))); // R11
    end

    AST_LOAD_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=>
            (ent_q[$past(wr_idx)].valid && ent_q[$past(wr_idx)].age == lat_t'(1))); // R9

endmodule

// File: rtl/lsb_bypass_resolver.sv
`timescale 1ns/1ps
module lsb_bypass_resolver
    import lsb_pkg::*;
(
    input  op_class_e             prod_cls,
    input  op_class_e             cons_cls,
    input  logic [NUM_GUARDS-1:0] guard,
    output lat_t                  lat
);

    logic [NUM_RULES-1:0] hit_g;
    logic [NUM_RULES-1:0] hit_u;
    lat_t                 rule_lat [NUM_RULES];

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
        localparam bypass_rule_t RL = rule_at(i);
        logic pair_match;
        assign pair_match  = (prod_cls == RL.prod) && RL.cons_mask[cons_cls];
        assign hit_g[i]    = RL.guarded && pair_match && guard[RL.guard_sel];
        assign hit_u[i]    = !RL.guarded && pair_match;
        assign rule_lat[i] = RL.lat;
    end

    lat_t lat_g, lat_u;
    logic any_g, any_u;

    always_comb begin
        lat_g = '0;
        lat_u = '0;
        any_g = 1'b0;
        any_u = 1'b0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (hit_g[i] && !any_g) begin
                any_g = 1'b1;
                lat_g = rule_lat[i];
            end
            if (hit_u[i] && !any_u) begin
                any_u = 1'b1;
                lat_u = rule_lat[i];
            end
        end
        if (any_g)      lat = lat_g;
        else if (any_u) lat = lat_u;
        else            lat = base_latency(prod_cls);
    end

endmodule

// File: rtl/lsb_wait_calc.sv
`timescale 1ns/1ps
module lsb_wait_calc
    import lsb_pkg::*;
(
    input  logic tracked,
    input  lat_t age,
    input  lat_t need,
    output lat_t wait_o
);

    assign wait_o = tracked ? sat_sub(need, age) : lat_t'(0);

endmodule

// File: rtl/latency_scoreboard.sv
`timescale 1ns/1ps
module latency_scoreboard
    import lsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_class,
    input  logic [REG_W-1:0]      req_dst,
    input  logic [REG_W-1:0]      req_src_a,
    input  logic [REG_W-1:0]      req_src_b,
    input  logic [NUM_GUARDS-1:0] req_guard,
    output logic                  issue_ok,
    output logic [LAT_W-1:0]      stall_cycles
);

    localparam int NUM_OPS = 3;   // two sources, then the destination

    op_class_e  req_cls;
    sb_entry_t  ent_q [NUM_REGS];
    logic [REG_W-1:0] op_idx [NUM_OPS];
    lat_t       need_lat [NUM_OPS];
    lat_t       op_wait  [NUM_OPS];
    lat_t       worst;
    logic       wr_en;

    assign req_cls   = op_class_e'(req_class);
    assign op_idx[0] = req_src_a;
    assign op_idx[1] = req_src_b;
    assign op_idx[2] = req_dst;

    lsb_entry_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_entries (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (req_dst),
        .wr_cls (req_cls),
        .ent_q  (ent_q)
    );

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        sb_entry_t ent;
        assign ent = ent_q[op_idx[k]];

        if (k < NUM_OPS - 1) begin : g_true_dep
            lsb_bypass_resolver u_res (
                .prod_cls (ent.cls),
                .cons_cls (req_cls),
                .guard    (req_guard),
                .lat      (need_lat[k])
            );
        end else begin : g_out_dep
            assign need_lat[k] = out_dep_cost(ent.cls, req_cls);
        end

        lsb_wait_calc u_wait (
            .tracked (ent.valid),
            .age     (ent.age),
            .need    (need_lat[k]),
            .wait_o  (op_wait[k])
        );
    end

    always_comb begin
        worst = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            if (op_wait[k] > worst) worst = op_wait[k];
        end
    end

    assign stall_cycles = worst;
    assign issue_ok     = req_valid && (worst == '0);
    assign wr_en        = issue_ok && (req_dst != '0);

    AST_REG0_FREE: assert property (@(posedge clk) disable iff (rst)
        (req_src_a == '0 && req_src_b == '0 && req_dst == '0) |-> stall_cycles == '0); // R8

    AST_FP_UNGUARDED: assert property (@(posedge clk) disable iff (rst)
        (ent_q[req_src_a].cls == CLS_FP && req_cls == CLS_INT && req_guard == '0)
            |-> need_lat[0] == lat_t'(4)); // R2

    AST_FIRST_GUARD: assert property (@(posedge clk) disable iff (rst)
        (ent_q[req_src_a].cls == CLS_FP && req_cls == CLS_INT && req_guard[0])
            |-> need_lat[0] == lat_t'(2)); // R4

    AST_INT_REWRITE_FREE: assert property (@(posedge clk) disable iff (rst)
        (req_src_a == '0 && req_src_b == '0 && ent_q[req_dst].cls == CLS_INT)
            |-> stall_cycles == '0); // R6

    AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stall_cycles) != '0 && $stable(req_class) &&
         $stable(req_dst) && $stable(req_src_a) && $stable(req_src_b) && $stable(req_guard))
            |-> stall_cycles == $past(stall_cycles) - LAT_W'(1)); // R11

endmodule

// File: tb/test_latency_scoreboard.sv
`timescale 1ns/1ps
module test_latency_scoreboard;

    typedef struct packed {
        logic       v;
        logic [1:0] cls;
        logic [4:0] dst;
        logic [4:0] sa;
        logic [4:0] sb;
        logic [1:0] g;
        logic       ok;
        logic [3:0] st;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    // v cls dst sa sb g | ok stall | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 5'd1, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd7},  // R7 int writes r1
        '{1'b1, 2'd0, 5'd2, 5'd1, 5'd0, 2'd0, 1'b0, 4'd1, 4'd1},  // R1 int->int k=1
        '{1'b1, 2'd0, 5'd2, 5'd1, 5'd0, 2'd0, 1'b1, 4'd0, 4'd11}, // R11 held, now issues
        '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 2'd0, 1'b0, 4'd0, 4'd7},  // R7 idle
        '{1'b1, 2'd3, 5'd3, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd1},  // R1 fp writes r3
        '{1'b0, 2'd0, 5'd0, 5'd3, 5'd0, 2'd0, 1'b0, 4'd3, 4'd2},  // R2 fp->int 4-1
        '{1'b0, 2'd0, 5'd0, 5'd3, 5'd0, 2'd3, 1'b0, 4'd0, 4'd4},  // R4 both guards, 2-2
        '{1'b0, 2'd0, 5'd0, 5'd3, 5'd0, 2'd2, 1'b0, 4'd2, 4'd3},  // R3 guard1 5-3
        '{1'b1, 2'd1, 5'd5, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd1},  // R1 mul writes r5
        '{1'b0, 2'd1, 5'd0, 5'd5, 5'd0, 2'd2, 1'b0, 4'd2, 4'd3},  // R3 mul->mul 3-1
        '{1'b0, 2'd1, 5'd0, 5'd5, 5'd0, 2'd0, 1'b0, 4'd2, 4'd1},  // R1 mul->mul 4-2
        '{1'b0, 2'd0, 5'd0, 5'd0, 5'd5, 2'd2, 1'b0, 4'd1, 4'd4},  // R4 guard no rule 4-3
        '{1'b1, 2'd1, 5'd6, 5'd5, 5'd0, 2'd2, 1'b1, 4'd0, 4'd3},  // R3 3-4 -> issue
        '{1'b0, 2'd0, 5'd6, 5'd0, 5'd0, 2'd0, 1'b0, 4'd1, 4'd6},  // R6 mul then int 2-1
        '{1'b0, 2'd2, 5'd6, 5'd0, 5'd0, 2'd0, 1'b0, 4'd0, 4'd6},  // R6 negative gap
        '{1'b1, 2'd2, 5'd7, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd1},  // R1 div writes r7
        '{1'b1, 2'd3, 5'd8, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd1},  // R1 fp writes r8
        '{1'b0, 2'd1, 5'd0, 5'd8, 5'd0, 2'd2, 1'b0, 4'd3, 4'd2},  // R2 fp->mul g1 4-1
        '{1'b0, 2'd0, 5'd7, 5'd8, 5'd0, 2'd0, 1'b0, 4'd4, 4'd7},  // R7 out 4 vs true 2
        '{1'b0, 2'd0, 5'd8, 5'd7, 5'd0, 2'd0, 1'b0, 4'd5, 4'd7},  // R7 true 5 vs out 0
        '{1'b1, 2'd2, 5'd0, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd8},  // R8 div writes r0
        '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 2'd0, 1'b0, 4'd0, 4'd8},  // R8 r0 not tracked
        '{1'b1, 2'd0, 5'd9, 5'd2, 5'd0, 2'd0, 1'b1, 4'd0, 4'd5},  // R5 reads r2
        '{1'b1, 2'd2, 5'd2, 5'd0, 5'd0, 2'd0, 1'b1, 4'd0, 4'd5},  // R5 writes r2 at once
        '{1'b0, 2'd0, 5'd0, 5'd2, 5'd0, 2'd0, 1'b0, 4'd8, 4'd9}   // R9 younger div 9-1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = '0;
    logic [4:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
    logic [1:0] req_guard = '0;
    logic       issue_ok;
    logic [3:0] stall_cycles;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    latency_scoreboard i_latency_scoreboard (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_class    (req_class),
        .req_dst      (req_dst),
        .req_src_a    (req_src_a),
        .req_src_b    (req_src_b),
        .req_guard    (req_guard),
        .issue_ok     (issue_ok),
        .stall_cycles (stall_cycles)
    );

    task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b, input logic [1:0] g);
        req_valid = v; req_class = c; req_dst = d;
        req_src_a = a; req_src_b = b; req_guard = g;
    endtask

    task automatic check(input int req, input logic ok_exp, input logic [3:0] st_exp);
        n_run++;
        if (issue_ok !== ok_exp || stall_cycles !== st_exp) begin
            n_fail++;
            $display("FAIL R%0d: issue_ok=%0b stall=%0d, expected issue_ok=%0b stall=%0d",
                     req, issue_ok, stall_cycles, ok_exp, st_exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: after reset every register is free
        drive(1'b0, 2'd0, 5'd4, 5'd1, 5'd3, 2'd0);
        #5 check(10, 1'b0, 4'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].v, VECS[i].cls, VECS[i].dst, VECS[i].sa, VECS[i].sb, VECS[i].g);
            #5 check(int'(VECS[i].req), VECS[i].ok, VECS[i].st);
        end

        // R11 and R1: divide result drains one step per cycle down to zero
        @(negedge clk);
        drive(1'b1, 2'd2, 5'd10, 5'd0, 5'd0, 2'd0);
        #5 check(1, 1'b1, 4'd0);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            drive(1'b1, 2'd0, 5'd0, 5'd10, 5'd0, 2'd0);
            #5 check(11, (k == 9), 4'(9 - k));
        end

        // R10: reset in flight discards a pending divide
        @(negedge clk);
        drive(1'b1, 2'd2, 5'd11, 5'd0, 5'd0, 2'd0);
        #5 check(1, 1'b1, 4'd0);
        @(negedge clk);
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 2'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 2'd0, 5'd11, 5'd11, 5'd0, 2'd0);
        #5 check(10, 1'b0, 4'd0);

        @(negedge clk);
        finish_run();
    end

endmodule